// File: doc/BRIEF.md
# Non-Power-of-Two Flash Page Address Translator

This block turns a linear byte address into the address a serial flash expects when its pages hold 264 or 528 bytes rather than a power of two. The linear address is divided by the page size. The quotient, which is the page number, is placed at bit 9 for 264-byte pages or at bit 10 for 528-byte pages. The remainder, which is the byte offset inside the page, fills the low bits. If the device has been switched to power-of-two mode, the linear address goes out unchanged.

A request is taken through a valid/ready handshake. A restoring shift-subtract divider then produces one quotient bit per clock. When the result is ready, a one-cycle `done` pulse appears together with the registered 24-bit device address and an error flag. The flag is raised when the address lies at or beyond the device capacity, which is the page size times the page count given with the request. The caller uses the result to build its own read, program or erase commands. An erase sector covers 8 pages, so a sector start is a device address whose page number is a multiple of 8.

Top module: `flash_addr_xlat`

## Requirements
- R1: After synchronous reset, `done` is 0, `err` is 0, `dev_addr` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle in which `done` is high.
- R3: `done` goes high AW+1 clock edges after the accepting edge (23 with defaults) and stays high for exactly one cycle.
- R4: With `pow2_mode`=0 and `big_page`=0 (page size 264), `dev_addr` = ((A / 264) << 9) | (A mod 264).
- R5: With `pow2_mode`=0 and `big_page`=1 (page size 528), `dev_addr` = ((A / 528) << 10) | (A mod 528).
- R6: With `pow2_mode`=1, `dev_addr` equals A zero-extended to 24 bits.
- R7: `err` is 1 in the `done` cycle when A >= P * `page_total`. P is 264 or 528 when `pow2_mode`=0, and 256 or 512 when `pow2_mode`=1, chosen by `big_page`. On error, `dev_addr` is 0.
- R8: A `req_valid` pulse while the block is busy is ignored, and the result belongs to the request that was accepted.
- R9: A new request can be accepted on the edge that ends the `done` cycle, with no idle cycle in between.
- R10: `dev_addr` and `err` keep their values from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| lin_addr | input | 22 | Linear byte address |
| big_page | input | 1 | 0: 264/256-byte pages, 1: 528/512-byte pages |
| pow2_mode | input | 1 | 1: device in power-of-two mode, address passed through |
| page_total | input | 13 | Number of pages in the device |
| dev_addr | output | 24 | Translated device address |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Address out of range, valid with done |

## Verification
The end of one conversion and the acceptance of the next can occur in the same cycle. While `done` is high, `req_ready` is already high again. The bench provokes this overlap by driving a new request during the very cycle in which it sees `done`. It then checks that `req_ready` was high at that point, that the first result was correct, and that the second result arrives with the full latency and its own value. Busy-time strobes and range-limit addresses are mixed into seeded random traffic, and every result is compared with a division model in the bench.

// File: rtl/flash_xlat_pkg.sv
package flash_xlat_pkg;
  localparam int SIZE_W = 10;
  localparam logic [SIZE_W-1:0] PG_SMALL = 10'd264;
  localparam logic [SIZE_W-1:0] PG_LARGE = 10'd528;
  localparam logic [SIZE_W-1:0] P2_SMALL = 10'd256;
  localparam logic [SIZE_W-1:0] P2_LARGE = 10'd512;

  function automatic logic [SIZE_W-1:0] page_bytes(input logic big, input logic p2);
    if (p2) return big ? P2_LARGE : P2_SMALL;
    return big ? PG_LARGE : PG_SMALL;
  endfunction
endpackage

// File: rtl/xlat_divider.sv
module xlat_divider #(
  parameter int AW = 22,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [AW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          fin
);
  localparam int CW = $clog2(AW + 1);

  logic [CW-1:0] cnt;
  logic          active;
  logic [DW-1:0] dvs;
  logic [DW:0]   trial;
  logic          qbit;

  assign trial = {rem, quo[AW-1]};
  assign qbit  = (trial >= {1'b0, dvs});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
      dvs    <= DW'(1);
      quo    <= '0;
      rem    <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load && !active) begin
        active <= 1'b1;
        cnt    <= CW'(AW);
        dvs    <= divisor;
        quo    <= dividend;
        rem    <= '0;
      end else if (active) begin
        quo <= {quo[AW-2:0], qbit};
        rem <= qbit ? DW'(trial - {1'b0, dvs}) : trial[DW-1:0];
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  // supports R4/R5: partial remainder never reaches the divisor
  assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (rst)
    (active || fin) |-> (rem < dvs));
  // supports R3: the finish strobe is one cycle wide
  assert_fin_single_R3: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
endmodule

// File: rtl/xlat_pack.sv
module xlat_pack #(
  parameter int AW    = 22,
  parameter int DW    = 10,
  parameter int DEV_W = 24
) (
  input  logic [AW-1:0]    quo,
  input  logic [DW-1:0]    rem,
  input  logic             big,
  output logic [DEV_W-1:0] packed_addr
);
  localparam int WW = AW + 10;

  logic [WW-1:0] wide;

  always_comb begin
    if (big) wide = {quo, 10'b0};
    else     wide = {1'b0, quo, 9'b0};
    packed_addr = wide[DEV_W-1:0] | {{(DEV_W-DW){1'b0}}, rem};
  end
endmodule

// File: rtl/flash_addr_xlat.sv
module flash_addr_xlat
  import flash_xlat_pkg::*;
#(
  parameter int AW    = 22,
  parameter int DEV_W = 24,
  parameter int PG_W  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    lin_addr,
  input  logic             big_page,
  input  logic             pow2_mode,
  input  logic [PG_W-1:0]  page_total,
  output logic [DEV_W-1:0] dev_addr,
  output logic             done,
  output logic             err
);
  localparam int DW    = SIZE_W;
  localparam int LIM_W = SIZE_W + PG_W + 1;

  logic             busy, accept;
  logic [AW-1:0]    lat_addr;
  logic             lat_big, lat_p2, lat_err;
  logic [LIM_W-1:0] limit;
  logic [AW-1:0]    quo;
  logic [DW-1:0]    rem;
  logic             fin;
  logic [DEV_W-1:0] packed_addr;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign limit     = LIM_W'(page_bytes(big_page, pow2_mode)) * LIM_W'(page_total);

  xlat_divider #(.AW(AW), .DW(DW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .dividend (lin_addr),
    .divisor  (page_bytes(big_page, 1'b0)),
    .quo      (quo),
    .rem      (rem),
    .fin      (fin)
  );

  xlat_pack #(.AW(AW), .DW(DW), .DEV_W(DEV_W)) u_pack (
    .quo         (quo),
    .rem         (rem),
    .big         (lat_big),
    .packed_addr (packed_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      lat_addr <= '0;
      lat_big  <= 1'b0;
      lat_p2   <= 1'b0;
      lat_err  <= 1'b0;
      dev_addr <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        lat_addr <= lin_addr;
        lat_big  <= big_page;
        lat_p2   <= pow2_mode;
        lat_err  <= (LIM_W'(lin_addr) >= limit);
      end
      if (fin) begin
        busy <= 1'b0;
        done <= 1'b1;
        err  <= lat_err;
        if (lat_err)     dev_addr <= '0;
        else if (lat_p2) dev_addr <= DEV_W'(lat_addr);
        else             dev_addr <= packed_addr;
      end
    end
  end

  assert_ready_low_busy_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_offset_small_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !err && !lat_p2 && !lat_big) |-> (dev_addr[8:0] < 9'(PG_SMALL)));
  assert_offset_large_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !err && !lat_p2 && lat_big) |-> (dev_addr[9:0] < PG_LARGE));
  assert_pow2_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !err && lat_p2) |-> (dev_addr == DEV_W'(lat_addr)));
  assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (dev_addr == '0));
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> $stable(lat_addr));
  assert_hold_result_R10: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(dev_addr) || done));
endmodule

// File: tb/test_flash_addr_xlat.sv
module test_flash_addr_xlat;
  localparam int LAT = 23;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [21:0] lin_addr = '0;
  logic        big_page = 1'b0;
  logic        pow2_mode = 1'b0;
  logic [12:0] page_total = '0;
  logic [23:0] dev_addr;
  logic        done;
  logic        err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_addr_xlat i_flash_addr_xlat (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .lin_addr(lin_addr), .big_page(big_page), .pow2_mode(pow2_mode),
    .page_total(page_total), .dev_addr(dev_addr), .done(done), .err(err)
  );

  function automatic int psize(bit big, bit p2);
    if (p2) return big ? 512 : 256;
    return big ? 528 : 264;
  endfunction

  function automatic bit exp_err(int a, bit big, bit p2, int n);
    return a >= psize(big, p2) * n;
  endfunction

  function automatic int exp_addr(int a, bit big, bit p2, int n);
    int ps;
    if (exp_err(a, big, p2, n)) return 0;
    if (p2) return a;
    ps = psize(big, 1'b0);
    return ((a / ps) << (big ? 10 : 9)) | (a % ps);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
    end
  endtask

  // pre: already at a negedge with the request not yet driven by caller
  // hold: return at the done negedge without waiting further
  task automatic do_req(int a, bit big, bit p2, int n, bit poke, bit pre, bit hold);
    int lat;
    string rq;
    if (!pre) @(negedge clk);
    if (pre) chk(req_ready == 1'b1, "R9", int'(req_ready), 1);
    req_valid = 1'b1; lin_addr = 22'(a); big_page = big; pow2_mode = p2; page_total = 13'(n);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", int'(req_ready), 0);
    lat = 0;
    while (!done && lat < 100) begin
      if (poke && lat < 10) begin
        req_valid = 1'b1; lin_addr = 22'(a ^ 22'h15A5A); big_page = ~big; pow2_mode = ~p2;
      end else begin
        req_valid = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(lat == LAT, "R3", lat, LAT);
    rq = p2 ? "R6" : (big ? "R5" : "R4");
    if (poke) rq = "R8";
    if (exp_err(a, big, p2, n)) rq = "R7";
    chk(int'(dev_addr) == exp_addr(a, big, p2, n), rq, int'(dev_addr), exp_addr(a, big, p2, n));
    chk(err == exp_err(a, big, p2, n), "R7", int'(err), int'(exp_err(a, big, p2, n)));
    if (!hold) begin
      @(posedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R3", int'(done), 0);
      chk(int'(dev_addr) == exp_addr(a, big, p2, n), "R10", int'(dev_addr), exp_addr(a, big, p2, n));
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1", int'(done), 0);
    chk(err == 1'b0, "R1", int'(err), 0);
    chk(dev_addr == 24'd0, "R1", int'(dev_addr), 0);
    chk(req_ready == 1'b1, "R1", int'(req_ready), 1);

    // directed corners: page boundaries (R4, R5)
    do_req(0,      1'b0, 1'b0, 2048, 1'b0, 1'b0, 1'b0);
    do_req(263,    1'b0, 1'b0, 2048, 1'b0, 1'b0, 1'b0);
    do_req(264,    1'b0, 1'b0, 2048, 1'b0, 1'b0, 1'b0);
    do_req(527,    1'b1, 1'b0, 4096, 1'b0, 1'b0, 1'b0);
    do_req(528,    1'b1, 1'b0, 4096, 1'b0, 1'b0, 1'b0);
    // R7 range edges
    do_req(264*2048-1, 1'b0, 1'b0, 2048, 1'b0, 1'b0, 1'b0);
    do_req(264*2048,   1'b0, 1'b0, 2048, 1'b0, 1'b0, 1'b0);
    do_req(528*4096-1, 1'b1, 1'b0, 4096, 1'b0, 1'b0, 1'b0);
    do_req(528*4096,   1'b1, 1'b0, 4096, 1'b0, 1'b0, 1'b0);
    do_req(512*4096-1, 1'b1, 1'b1, 4096, 1'b0, 1'b0, 1'b0);
    do_req(256*512,    1'b0, 1'b1, 512,  1'b0, 1'b0, 1'b0);
    // R6 pass-through
    do_req(12345,  1'b0, 1'b1, 2048, 1'b0, 1'b0, 1'b0);
    // R8 strobes while busy
    do_req(100000, 1'b1, 1'b0, 4096, 1'b1, 1'b0, 1'b0);
    // R9 back-to-back acceptance in the done cycle
    do_req(5000,   1'b0, 1'b0, 2048, 1'b0, 1'b0, 1'b1);
    do_req(70000,  1'b1, 1'b0, 4096, 1'b0, 1'b1, 1'b0);

    // seeded random traffic
    for (int i = 0; i < 200; i++) begin
      bit big, p2, poke;
      int n, lim, a;
      big  = 1'($urandom);
      p2   = ($urandom % 4) == 0;
      poke = ($urandom % 8) == 0;
      n    = 1 + int'($urandom % 8191);
      lim  = psize(big, p2) * n;
      if (($urandom % 4) == 0) a = int'($urandom % 32'h400000);
      else a = int'($urandom % lim);
      if (a > 32'h3FFFFF) a = a & 32'h3FFFFF;
      do_req(a, big, p2, n, poke, 1'b0, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule